// File: doc/BRIEF.md
# SPI Event Packet Reader with Status Handshake

This block is an SPI master that pulls variable-length event packets out of a peripheral. The peripheral signals that it has data by raising an interrupt line. When the reader is enabled and idle, it drops chip select and exchanges a five-byte status header. The header tells the reader whether the peripheral is ready and how many bytes it holds. If the peripheral is not ready or has nothing to send, the reader briefly raises chip select, lowers it again and repeats the header exchange. It keeps doing this while the interrupt stays high. Once the header is valid, the reader clocks the payload in by sending filler bytes and writes each received byte into a local buffer.

The number of bytes read is the peripheral's count, capped at the buffer capacity given on an input. After the last byte the reader waits for the shifter to go idle and then releases chip select. One clock later it emits a single-cycle done pulse that carries the length. If the interrupt has already fallen when an invalid header arrives, the reader releases chip select and ends the read without a payload and without a done pulse. The serial clock comes from a parameterised divider of the system clock.

Top module: `spi_evt_reader`

## Requirements
- R1: After reset, cs_no is high, sclk_o is low, and buf_we_o and done_o are low.
- R2: Frames use SPI mode 0 with 8 bits, MSB first. sclk_o idles low, MOSI changes on the falling edge and MISO is sampled on the rising edge. sclk_o toggles only while cs_no is low. Each header exchange sends 0x0B and then four 0x00 bytes.
- R3: A header is valid when received byte 0 equals 0x02 and the 16-bit count is non-zero. The count is formed from byte 3 as the low byte and byte 4 as the high byte.
- R4: An invalid header while irq_i is high makes cs_no go high for GAP_CYC cycles and then low again, and the five-byte header exchange is repeated.
- R5: An invalid header while irq_i is low releases cs_no and ends the read: no buffer write and no done pulse.
- R6: During the payload phase every byte sent on MOSI is 0xFF.
- R7: The payload length is min(count, buf_cap_i). Received byte k (k = 0..len-1) is written to buf_addr_o = k with buf_we_o high for one cycle. A capacity of 0 reads no payload.
- R8: cs_no rises only while the byte shifter is idle and sclk_o is low.
- R9: done_o is high for exactly one clock, one cycle after cs_no has risen at the end of a successful read. It carries done_len_o equal to the clamped length.
- R10: A rising edge on irq_i while a read is in progress is ignored. No new read follows unless irq_i rises again while the reader is idle.
- R11: A rising edge on irq_i while rx_en_i is low starts nothing. If rx_en_i rises while irq_i is already high, a read starts at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 1 | Service request from the peripheral |
| rx_en_i | input | 1 | Receive path enable |
| buf_cap_i | input | 16 | Buffer capacity in bytes |
| miso_i | input | 1 | Serial data from the peripheral |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the peripheral |
| cs_no | output | 1 | Chip select, active low |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_addr_o | output | 16 | Buffer write address |
| buf_data_o | output | 8 | Buffer write data |
| done_o | output | 1 | One-cycle read-complete pulse |
| done_len_o | output | 16 | Length of the completed read |

## Verification
The bench builds the reader with CLK_DIV = 2 and GAP_CYC = 2. With these values a byte takes 32 clocks, so reads with several retries and clamped payloads finish in a few hundred cycles. A bench-side peripheral model answers each chip-select session with its own header. This allows counts that need the high byte, zero counts, wrong ready codes, retry chains and capacities of 0 and 1, all in one run. The short gap makes the chip-select pulse between retries observable at the ports.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
  localparam int BYTE_W    = 8;
  localparam int BIT_W     = $clog2(BYTE_W);
  localparam int CNT_W     = 16;
  localparam int HDR_BYTES = 5;

  localparam logic [BYTE_W-1:0] HDR_READ = 8'h0B;
  localparam logic [BYTE_W-1:0] HDR_PAD  = 8'h00;
  localparam logic [BYTE_W-1:0] RDY_CODE = 8'h02;
  localparam logic [BYTE_W-1:0] FILLER   = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_HDR, ST_CHECK, ST_GAP, ST_PAY, ST_RELEASE, ST_DONE
  } rd_state_e;
endpackage

// File: rtl/spi_byte_shift.sv
module spi_byte_shift
  import spi_evt_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] tx_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rx_o,
  output logic              sclk_o,
  output logic              mosi_o
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

  logic              busy_q, sclk_q, done_q;
  logic [DIV_W-1:0]  div_q;
  logic [BIT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          tx_q   <= tx_i;
          div_q  <= '0;
          bit_q  <= '0;
          sclk_q <= 1'b0;
        end
      end else if (div_q == DIV_LAST) begin
        div_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[BYTE_W-2:0], miso_i};
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == BIT_LAST) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
            tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sclk_o = sclk_q;
  assign mosi_o = tx_q[BYTE_W-1];

  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q); // R2
  AST_SCLK_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_q |-> busy_q); // R2
endmodule

// File: rtl/evt_rd_ctrl.sv
module evt_rd_ctrl
  import spi_evt_pkg::*;
#(
  parameter int GAP_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  input  logic              rx_en_i,
  input  logic [CNT_W-1:0]  buf_cap_i,
  input  logic              sh_busy_i,
  input  logic              sh_done_i,
  input  logic [BYTE_W-1:0] sh_rx_i,
  output logic              sh_start_o,
  output logic [BYTE_W-1:0] sh_tx_o,
  output logic              cs_no,
  output logic              buf_we_o,
  output logic [CNT_W-1:0]  buf_addr_o,
  output logic [BYTE_W-1:0] buf_data_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  done_len_o
);
  localparam int GAP_W = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BYTES - 1);

  rd_state_e         state_q;
  logic              irq_q, en_q, inflight_q;
  logic [CNT_W-1:0]  idx_q, cnt_q, len_q;
  logic [BYTE_W-1:0] rdy_q;
  logic [GAP_W-1:0]  gap_q;
  logic              start_req, hdr_ok;
  logic [CNT_W-1:0]  len_clamp;

  // edge-qualified request: irq rising, or enable rising while irq is high
  assign start_req = rx_en_i && irq_i && (!irq_q || !en_q);
  assign hdr_ok    = (rdy_q == RDY_CODE) && (cnt_q != '0);
  assign len_clamp = (cnt_q > buf_cap_i) ? buf_cap_i : cnt_q;

  assign sh_start_o = ((state_q == ST_HDR) || (state_q == ST_PAY)) && !sh_busy_i && !inflight_q;
  assign sh_tx_o    = (state_q == ST_PAY) ? FILLER : ((idx_q == '0) ? HDR_READ : HDR_PAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      irq_q      <= 1'b0;
      en_q       <= 1'b0;
      inflight_q <= 1'b0;
      idx_q      <= '0;
      cnt_q      <= '0;
      len_q      <= '0;
      rdy_q      <= '0;
      gap_q      <= '0;
      cs_no      <= 1'b1;
      buf_we_o   <= 1'b0;
      buf_addr_o <= '0;
      buf_data_o <= '0;
      done_o     <= 1'b0;
      done_len_o <= '0;
    end else begin
      irq_q    <= irq_i;
      en_q     <= rx_en_i;
      buf_we_o <= 1'b0;
      done_o   <= 1'b0;
      if (sh_start_o)     inflight_q <= 1'b1;
      else if (sh_done_i) inflight_q <= 1'b0;

      unique case (state_q)
        ST_IDLE: if (start_req) begin
          cs_no   <= 1'b0;
          state_q <= ST_SETUP;
        end
        ST_SETUP: begin
          idx_q   <= '0;
          state_q <= ST_HDR;
        end
        ST_HDR: if (sh_done_i) begin
          if (idx_q == '0)      rdy_q              <= sh_rx_i;
          if (idx_q == CNT_W'(3)) cnt_q[BYTE_W-1:0] <= sh_rx_i;
          if (idx_q == CNT_W'(4)) cnt_q[CNT_W-1:BYTE_W] <= sh_rx_i;
          if (idx_q == HDR_LAST) begin
            idx_q   <= '0;
            state_q <= ST_CHECK;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_CHECK: begin
          if (hdr_ok) begin
            len_q   <= len_clamp;
            state_q <= (len_clamp == '0) ? ST_RELEASE : ST_PAY;
          end else if (irq_i) begin
            cs_no   <= 1'b1;
            gap_q   <= '0;
            state_q <= ST_GAP;
          end else begin
            cs_no   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_GAP: begin
          if (gap_q == GAP_LAST) begin
            cs_no   <= 1'b0;
            state_q <= ST_SETUP;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        ST_PAY: if (sh_done_i) begin
          buf_we_o   <= 1'b1;
          buf_addr_o <= idx_q;
          buf_data_o <= sh_rx_i;
          if (idx_q == len_q - 1'b1) state_q <= ST_RELEASE;
          else                       idx_q   <= idx_q + 1'b1;
        end
        ST_RELEASE: if (!sh_busy_i) begin
          cs_no   <= 1'b1;
          state_q <= ST_DONE;
        end
        ST_DONE: begin
          done_o     <= 1'b1;
          done_len_o <= len_q;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_WRITE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> (buf_addr_o < len_q)); // R7
  AST_WRITE_UNDER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> !cs_no); // R7
  AST_IDLE_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> cs_no); // R5
endmodule

// File: rtl/spi_evt_reader.sv
module spi_evt_reader
  import spi_evt_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int GAP_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  input  logic              rx_en_i,
  input  logic [CNT_W-1:0]  buf_cap_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              cs_no,
  output logic              buf_we_o,
  output logic [CNT_W-1:0]  buf_addr_o,
  output logic [BYTE_W-1:0] buf_data_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  done_len_o
);
  logic              sh_start, sh_busy, sh_done;
  logic [BYTE_W-1:0] sh_tx, sh_rx;

  spi_byte_shift #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sh_start),
    .tx_i    (sh_tx),
    .miso_i  (miso_i),
    .busy_o  (sh_busy),
    .done_o  (sh_done),
    .rx_o    (sh_rx),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o)
  );

  evt_rd_ctrl #(.GAP_CYC(GAP_CYC)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_i      (irq_i),
    .rx_en_i    (rx_en_i),
    .buf_cap_i  (buf_cap_i),
    .sh_busy_i  (sh_busy),
    .sh_done_i  (sh_done),
    .sh_rx_i    (sh_rx),
    .sh_start_o (sh_start),
    .sh_tx_o    (sh_tx),
    .cs_no      (cs_no),
    .buf_we_o   (buf_we_o),
    .buf_addr_o (buf_addr_o),
    .buf_data_o (buf_data_o),
    .done_o     (done_o),
    .done_len_o (done_len_o)
  );

  AST_CS_RISE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> (!sh_busy && !sclk_o)); // R8
  AST_SCLK_UNDER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no); // R2
  AST_DONE_AFTER_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(cs_no) && !$past(cs_no, 2))); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
endmodule

// File: tb/spi_evt_reader_tb.sv
module spi_evt_reader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic        rx_en = 1'b1;
  logic [15:0] cap = 16'd8;
  logic        miso;
  logic        sclk, mosi, cs_n, we, done;
  logic [15:0] addr, dlen;
  logic [7:0]  wdata;

  always #10 clk = ~clk;

  spi_evt_reader #(.CLK_DIV(2), .GAP_CYC(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .rx_en_i(rx_en), .buf_cap_i(cap),
    .miso_i(miso), .sclk_o(sclk), .mosi_o(mosi), .cs_no(cs_n),
    .buf_we_o(we), .buf_addr_o(addr), .buf_data_o(wdata),
    .done_o(done), .done_len_o(dlen)
  );

  int checks = 0, errors = 0, cycles = 0;
  // peripheral model configuration
  int          v_nbad = 0;
  logic [7:0]  v_bad_rdy = 8'h00;
  logic [15:0] v_cnt = 16'd0;
  // observations
  int sess_cnt = 0, cur_sess = 0, sidx = 0, bitc = 0, mosi_bad = 0;
  int wcount = 0, wr_bad = 0, done_cnt = 0, tim_bad = 0, cs_sclk_bad = 0;
  logic [15:0] last_len = '0;
  logic [7:0]  sh = 8'h00, mrx = 8'h00;
  logic        cs_p1 = 1'b1, cs_p2 = 1'b1;

  // {nbad, bad ready code, count, capacity}
  localparam logic [43:0] VEC [7] = '{
    {4'd0, 8'h00, 16'd4,   16'd8},
    {4'd1, 8'h00, 16'd3,   16'd8},
    {4'd2, 8'h02, 16'd5,   16'd5},
    {4'd0, 8'h00, 16'd300, 16'd6},
    {4'd1, 8'h55, 16'd258, 16'd10},
    {4'd0, 8'h00, 16'd1,   16'd1},
    {4'd0, 8'h00, 16'd3,   16'd0}
  };

  function automatic logic [7:0] pat(int k);
    return 8'((k * 29) + 8'h11);
  endfunction

  function automatic logic [7:0] resp(int s, int i);
    logic        ok;
    logic [15:0] c;
    ok = (s >= v_nbad);
    c  = ok ? v_cnt : ((v_bad_rdy == 8'h02) ? 16'd0 : v_cnt);
    if (i == 0) return ok ? 8'h02 : v_bad_rdy;
    if (i == 3) return c[7:0];
    if (i == 4) return c[15:8];
    if (i < 5)  return 8'h5A;
    return pat(i - 5);
  endfunction

  assign miso = sh[7];

  always @(negedge cs_n) begin
    cur_sess = sess_cnt;
    sess_cnt = sess_cnt + 1;
    sidx = 0;
    bitc = 0;
    sh = resp(cur_sess, 0);
  end

  always @(posedge sclk) if (!cs_n) mrx = {mrx[6:0], mosi};

  always @(negedge sclk) if (!cs_n) begin
    bitc = bitc + 1;
    if (bitc == 8) begin
      if (sidx < 5) begin
        if (mrx != ((sidx == 0) ? 8'h0B : 8'h00)) mosi_bad = mosi_bad + 1;
      end else if (mrx != 8'hFF) mosi_bad = mosi_bad + 1;
      sidx = sidx + 1;
      bitc = 0;
      sh = resp(cur_sess, sidx);
    end else begin
      sh = {sh[6:0], 1'b0};
    end
  end

  always @(negedge clk) begin
    cycles = cycles + 1;
    if (rst_n) begin
      if (we) begin
        if (addr != 16'(wcount) || wdata != pat(wcount)) wr_bad = wr_bad + 1;
        wcount = wcount + 1;
      end
      if (done) begin
        done_cnt = done_cnt + 1;
        last_len = dlen;
        if (!(cs_n && cs_p1 && !cs_p2)) tim_bad = tim_bad + 1;
      end
      if (cs_n && !cs_p1 && sclk) cs_sclk_bad = cs_sclk_bad + 1;
    end
    cs_p2 = cs_p1;
    cs_p1 = cs_n;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_obs();
    sess_cnt = 0; wcount = 0; wr_bad = 0; mosi_bad = 0;
  endtask

  task automatic wait_done(input int d0, input int lim);
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (done_cnt > d0) break;
    end
  endtask

  initial begin
    int d0, exp_len;
    #5;
    @(negedge clk);
    check(cs_n == 1'b1, "R1 cs", int'(cs_n), 1);
    check(sclk == 1'b0, "R1 sclk", int'(sclk), 0);
    check(we == 1'b0, "R1 we", int'(we), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk: R2 R3 R4 R6 R7 R9
    for (int v = 0; v < 7; v++) begin
      v_nbad = int'(VEC[v][43:40]);
      v_bad_rdy = VEC[v][39:32];
      v_cnt = VEC[v][31:16];
      cap = VEC[v][15:0];
      exp_len = (v_cnt > cap) ? int'(cap) : int'(v_cnt);
      clear_obs();
      d0 = done_cnt;
      irq = 1'b1;
      wait_done(d0, 5000);
      check(done_cnt == d0 + 1, "R9 one done", done_cnt - d0, 1);
      check(int'(last_len) == exp_len, "R7 length", int'(last_len), exp_len);
      check(sess_cnt == v_nbad + 1, "R4 sessions", sess_cnt, v_nbad + 1);
      check(wcount == exp_len, "R7 writes", wcount, exp_len);
      check(wr_bad == 0, "R7 data", wr_bad, 0);
      check(mosi_bad == 0, "R2 R6 mosi", mosi_bad, 0);
      irq = 1'b0;
      repeat (20) @(negedge clk);
    end
    check(tim_bad == 0, "R9 timing", tim_bad, 0);
    check(cs_sclk_bad == 0, "R8 release", cs_sclk_bad, 0);

    // R5: invalid header after irq has fallen
    v_nbad = 1; v_bad_rdy = 8'h00; v_cnt = 16'd4; cap = 16'd8;
    clear_obs();
    d0 = done_cnt;
    irq = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (!cs_n) break;
    end
    repeat (40) @(negedge clk);
    irq = 1'b0;
    repeat (600) @(negedge clk);
    check(sess_cnt == 1, "R5 sessions", sess_cnt, 1);
    check(done_cnt == d0, "R5 no done", done_cnt - d0, 0);
    check(wcount == 0, "R5 no writes", wcount, 0);
    check(cs_n == 1'b1, "R5 cs released", int'(cs_n), 1);

    // R10: irq re-rise during a read is dropped
    v_nbad = 0; v_cnt = 16'd6; cap = 16'd6;
    clear_obs();
    d0 = done_cnt;
    irq = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (wcount > 0) break;
    end
    irq = 1'b0;
    repeat (2) @(negedge clk);
    irq = 1'b1;
    wait_done(d0, 3000);
    repeat (400) @(negedge clk);
    check(done_cnt == d0 + 1, "R10 done count", done_cnt - d0, 1);
    check(sess_cnt == 1, "R10 no restart", sess_cnt, 1);
    check(cs_n == 1'b1, "R10 idle", int'(cs_n), 1);
    irq = 1'b0;
    repeat (10) @(negedge clk);

    // R11: disabled path, then enable with irq high
    v_cnt = 16'd2; cap = 16'd8;
    clear_obs();
    rx_en = 1'b0;
    repeat (3) @(negedge clk);
    irq = 1'b1;
    repeat (200) @(negedge clk);
    check(sess_cnt == 0, "R11 disabled", sess_cnt, 0);
    d0 = done_cnt;
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
    check(cs_n == 1'b0, "R11 start on enable", int'(cs_n), 0);
    wait_done(d0, 3000);
    check(int'(last_len) == 2, "R11 length", int'(last_len), 2);
    irq = 1'b0;
    repeat (10) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks = checks + 1;
    errors = errors + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule